// File: doc/BRIEF.md
# Address Match Break Controller

This block watches the CPU address bus and raises a break interrupt request when a valid bus address equals a programmed break address. The break address is held in byte-wide registers, most significant byte first. A control byte holds an enable flag and an active flag. Software can arm matching through the enable flag. It can also force a break directly by writing a 1 to the active flag.

While a break is active, the block drives a freeze output that holds the timer counter. It also drives a watchdog-disable output, but only when the test-voltage input is high. The break request stays up until the break routine writes 0 to the active flag.

Stop mode suspends address matching and leaves all stored values unchanged. Wait mode has no effect on matching.

Top module: `addr_break_ctrl`

## Requirements
- R1: After reset the break address bytes and the control byte read 0x00, and `brk_irq`, `tmr_freeze` and `wdog_dis` are low.
- R2: Offset 0 selects the high break-address byte and offset 1 the low byte. Each reads back the last value written to it. Offset 3 reads 0x00.
- R3: Offset 2 selects the control byte. Bit 7 is the enable flag and bit 6 the active flag, both readable and writable. Bits 5..0 always read 0.
- R4: With the enable flag at 1, a cycle with `cpu_addr_vld` high and `cpu_addr` equal to {high byte, low byte} sets the active flag. `brk_irq` is high from the next cycle on.
- R5: No break is raised by a matching address while the enable flag is 0, by a matching address while `cpu_addr_vld` is low, or by an address that differs from the break address in any single bit.
- R6: Writing the control byte with bit 6 at 1 sets the active flag on the next cycle, whatever the enable flag and the bus address are.
- R7: Once set, the active flag and `brk_irq` stay high until software writes the control byte with bit 6 at 0. They are low from the cycle after that write.
- R8: If an address match and a control write with bit 6 at 0 occur in the same cycle, the active flag ends up at 1.
- R9: While `stop_mode` is high, matching addresses raise no break, and all register values read back unchanged.
- R10: While `wait_mode` is high, matching works exactly as in run mode.
- R11: `tmr_freeze` is high exactly when the active flag is 1.
- R12: `wdog_dis` is high exactly when the active flag is 1 and `test_volt` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cpu_addr | input | 16 | CPU bus address |
| cpu_addr_vld | input | 1 | CPU bus address is valid this cycle |
| wait_mode | input | 1 | Core is in wait mode |
| stop_mode | input | 1 | Core is in stop mode |
| test_volt | input | 1 | Test voltage present |
| brk_irq | output | 1 | Break interrupt request |
| tmr_freeze | output | 1 | Hold the timer counter |
| wdog_dis | output | 1 | Disable the watchdog |

## Verification
Several rules are checked by assertions on every cycle:
- A qualified match or a forcing write is followed by an active break.
- An active break persists until a clearing write.
- The flag never rises without a cause, including in stop mode.
- The watchdog-disable output requires both the active flag and the test voltage.
- The padding bits of the control byte read zero.

Other behaviours can only be shown by the bench's scenarios. These are the readback sweeps over every byte value, each single-bit near miss around many break addresses, the tie between a match and a clearing write, and the unchanged register contents after a stop-mode interval.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int BRK_ADDR_W = 16;
    localparam int BRK_DATA_W = 8;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_WAIT = 2'd1,
        PWR_STOP = 2'd2
    } pwr_mode_e;

    typedef struct packed {
        logic en;
        logic act;
    } brk_ctl_t;

    function automatic pwr_mode_e decode_mode(input logic stop_i, input logic wait_i);
        if (stop_i)
            return PWR_STOP;
        else if (wait_i)
            return PWR_WAIT;
        return PWR_RUN;
    endfunction

    function automatic logic compare_allowed(input pwr_mode_e m);
        return (m == PWR_RUN) || (m == PWR_WAIT);
    endfunction

endpackage

// File: rtl/brk_addr_regs.sv
module brk_addr_regs #(
    parameter int ADDR_W = brk_pkg::BRK_ADDR_W,
    parameter int DATA_W = brk_pkg::BRK_DATA_W,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] brk_addr
);
    localparam int NB = ADDR_W / DATA_W;

    logic [DATA_W-1:0] byte_q [NB];

    // Byte 0 is the most significant byte of the break address
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NB; i++)
                byte_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NB; i++)
                if (ofs == OFS_W'(i))
                    byte_q[i] <= wdata;
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_pack
        assign brk_addr[ADDR_W-1-g*DATA_W -: DATA_W] = byte_q[g];
    end

endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
    parameter int ADDR_W = brk_pkg::BRK_ADDR_W
) (
    input  logic                cmp_en,
    input  brk_pkg::pwr_mode_e  mode,
    input  logic                addr_vld,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ADDR_W-1:0]   brk_addr,
    output logic                hit
);
    logic same;

    always_comb begin
        same = (addr == brk_addr);
        hit  = cmp_en && addr_vld && same && brk_pkg::compare_allowed(mode);
    end

endmodule

// File: rtl/brk_status.sv
module brk_status #(
    parameter int DATA_W = brk_pkg::BRK_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    input  logic              test_volt,
    output brk_pkg::brk_ctl_t ctl,
    output logic              brk_irq,
    output logic              tmr_freeze,
    output logic              wdog_dis
);
    localparam int EN_BIT  = DATA_W - 1;
    localparam int ACT_BIT = DATA_W - 2;

    brk_pkg::brk_ctl_t ctl_q, ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we) begin
            ctl_d.en  = wdata[EN_BIT];
            ctl_d.act = wdata[ACT_BIT];
        end
        // a match outranks a simultaneous clearing write
        if (hit)
            ctl_d.act = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    assign ctl        = ctl_q;
    assign brk_irq    = ctl_q.act;
    assign tmr_freeze = ctl_q.act;
    assign wdog_dis   = ctl_q.act && test_volt;

endmodule

// File: rtl/addr_break_ctrl.sv
module addr_break_ctrl #(
    parameter int ADDR_W = brk_pkg::BRK_ADDR_W,
    parameter int DATA_W = brk_pkg::BRK_DATA_W,
    parameter int OFS_W  = $clog2(ADDR_W / DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_addr_vld,
    input  logic              wait_mode,
    input  logic              stop_mode,
    input  logic              test_volt,
    output logic              brk_irq,
    output logic              tmr_freeze,
    output logic              wdog_dis
);
    localparam int NB       = ADDR_W / DATA_W;
    localparam int STAT_OFS = NB;

    brk_pkg::pwr_mode_e mode;
    brk_pkg::brk_ctl_t  ctl;
    logic [ADDR_W-1:0]  brk_addr;
    logic               hit;
    logic               ctl_we;
    logic               ctl_en;

    assign mode   = brk_pkg::decode_mode(stop_mode, wait_mode);
    assign ctl_we = reg_we && (reg_addr == OFS_W'(STAT_OFS));
    assign ctl_en = ctl.en;

    brk_addr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .ofs      (reg_addr),
        .wdata    (reg_wdata),
        .brk_addr (brk_addr)
    );

    brk_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .cmp_en   (ctl.en),
        .mode     (mode),
        .addr_vld (cpu_addr_vld),
        .addr     (cpu_addr),
        .brk_addr (brk_addr),
        .hit      (hit)
    );

    brk_status #(.DATA_W(DATA_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .wdata      (reg_wdata),
        .hit        (hit),
        .test_volt  (test_volt),
        .ctl        (ctl),
        .brk_irq    (brk_irq),
        .tmr_freeze (tmr_freeze),
        .wdog_dis   (wdog_dis)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NB; i++)
            if (reg_addr == OFS_W'(i))
                reg_rdata = brk_addr[ADDR_W-1-i*DATA_W -: DATA_W];
        if (reg_addr == OFS_W'(STAT_OFS))
            reg_rdata = {ctl.en, ctl.act, {(DATA_W-2){1'b0}}};
    end

endmodule

// File: rtl/brk_chk.sv
module brk_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [OFS_W-1:0]  reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_addr_vld,
    input logic              stop_mode,
    input logic              test_volt,
    input logic              brk_irq,
    input logic              wdog_dis,
    input logic [ADDR_W-1:0] brk_addr,
    input logic              ctl_en
);
    localparam int STAT_OFS = ADDR_W / DATA_W;
    localparam int ACT_BIT  = DATA_W - 2;

    logic stat_wr, match_now;
    assign stat_wr   = reg_we && (reg_addr == OFS_W'(STAT_OFS));
    assign match_now = ctl_en && cpu_addr_vld && !stop_mode && (cpu_addr == brk_addr);

    // R4
    match_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
        match_now |=> brk_irq);

    // R6
    force_write_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && reg_wdata[ACT_BIT]) |=> brk_irq);

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_irq && !(stat_wr && !reg_wdata[ACT_BIT])) |=> brk_irq);

    // R5
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!brk_irq && !stat_wr && !match_now) |=> !brk_irq);

    // R9
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !brk_irq && !stat_wr) |=> !brk_irq);

    // R12
    wdog_cond_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_dis |-> (brk_irq && test_volt));

    // R3
    ctl_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_W'(STAT_OFS)) |-> (reg_rdata[ACT_BIT-1:0] == '0));

endmodule

bind addr_break_ctrl brk_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_we       (reg_we),
    .reg_rdata    (reg_rdata),
    .cpu_addr     (cpu_addr),
    .cpu_addr_vld (cpu_addr_vld),
    .stop_mode    (stop_mode),
    .test_volt    (test_volt),
    .brk_irq      (brk_irq),
    .wdog_dis     (wdog_dis),
    .brk_addr     (brk_addr),
    .ctl_en       (ctl_en)
);

// File: tb/addr_break_ctrl_bench.sv
module addr_break_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = '0;
    logic        cpu_addr_vld = 1'b0;
    logic        wait_mode = 1'b0;
    logic        stop_mode = 1'b0;
    logic        test_volt = 1'b0;
    logic        brk_irq, tmr_freeze, wdog_dis;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    addr_break_ctrl u_addr_break_ctrl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .cpu_addr_vld(cpu_addr_vld), .wait_mode(wait_mode), .stop_mode(stop_mode),
        .test_volt(test_volt), .brk_irq(brk_irq), .tmr_freeze(tmr_freeze),
        .wdog_dis(wdog_dis)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_wr(input logic [1:0] ofs, input logic [7:0] d);
        reg_addr = ofs; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] ofs, output logic [7:0] d);
        reg_addr = ofs;
        #1;
        d = reg_rdata;
    endtask

    task automatic bus(input logic [15:0] a, input logic v);
        cpu_addr = a; cpu_addr_vld = v;
        step();
        cpu_addr_vld = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [15:0] ba;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        reg_rd(2'd0, rd); check("R1 hi", rd, 0);
        reg_rd(2'd1, rd); check("R1 lo", rd, 0);
        reg_rd(2'd2, rd); check("R1 ctl", rd, 0);
        check("R1 irq", brk_irq, 0);
        check("R1 freeze", tmr_freeze, 0);
        check("R1 wdog", wdog_dis, 0);

        // R2 exhaustive byte readback, R2 offset 3 reads zero
        for (int v = 0; v < 256; v++) begin
            reg_wr(2'd0, 8'(v));
            reg_wr(2'd1, 8'(255 - v));
            reg_rd(2'd0, rd); check("R2 hi", rd, v);
            reg_rd(2'd1, rd); check("R2 lo", rd, 255 - v);
            reg_rd(2'd3, rd); check("R2 ofs3", rd, 0);
        end

        // R3 R6 R7 R11 R12 control byte sweep, no bus traffic
        for (int v = 0; v < 256; v++) begin
            test_volt = v[0];
            reg_wr(2'd2, 8'(v));
            reg_rd(2'd2, rd);
            check("R3 ctl readback", rd, v & 8'hC0);
            check("R6 forced irq", brk_irq, (v >> 6) & 1);
            check("R11 freeze", tmr_freeze, (v >> 6) & 1);
            check("R12 wdog", wdog_dis, ((v >> 6) & 1) & v[0]);
            step();
            check("R7 hold", brk_irq, (v >> 6) & 1);
            reg_wr(2'd2, 8'h00);
            check("R7 clear", brk_irq, 0);
        end
        test_volt = 1'b0;

        // R4 R5 match and single-bit near misses over many break addresses
        for (int k = 0; k < 22; k++) begin
            ba = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'((k * 16'h1357 + 16'h0101));
            reg_wr(2'd0, ba[15:8]);
            reg_wr(2'd1, ba[7:0]);
            reg_wr(2'd2, 8'h80);
            for (int b = 0; b < 16; b++) begin
                bus(ba ^ (16'h1 << b), 1'b1);
                check("R5 near miss", brk_irq, 0);
            end
            bus(ba, 1'b0);
            check("R5 invalid", brk_irq, 0);
            bus(ba, 1'b1);
            check("R4 match", brk_irq, 1);
            reg_wr(2'd2, 8'h00);
            bus(ba, 1'b1);
            check("R5 disabled", brk_irq, 0);
        end

        // R8 match wins over clearing write
        reg_wr(2'd0, 8'hA5); reg_wr(2'd1, 8'h3C);
        reg_wr(2'd2, 8'hC0);
        cpu_addr = 16'hA53C; cpu_addr_vld = 1'b1;
        reg_wr(2'd2, 8'h80);
        cpu_addr_vld = 1'b0;
        check("R8 tie", brk_irq, 1);
        reg_wr(2'd2, 8'h80);
        check("R8 cleared", brk_irq, 0);

        // R9 stop mode suppresses match, keeps registers
        stop_mode = 1'b1;
        for (int i = 0; i < 4; i++) begin
            bus(16'hA53C, 1'b1);
            check("R9 stop no break", brk_irq, 0);
        end
        reg_rd(2'd0, rd); check("R9 hi kept", rd, 8'hA5);
        reg_rd(2'd1, rd); check("R9 lo kept", rd, 8'h3C);
        reg_rd(2'd2, rd); check("R9 ctl kept", rd, 8'h80);
        stop_mode = 1'b0;

        // R10 wait mode still matches
        wait_mode = 1'b1;
        bus(16'hA53D, 1'b1);
        check("R10 wait miss", brk_irq, 0);
        bus(16'hA53C, 1'b1);
        check("R10 wait match", brk_irq, 1);
        test_volt = 1'b1; #1;
        check("R12 wdog on", wdog_dis, 1);
        check("R11 freeze on", tmr_freeze, 1);
        wait_mode = 1'b0;
        reg_wr(2'd2, 8'h00);
        check("R7 final clear", brk_irq, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule